// File: doc/BRIEF.md
# Reorder-Buffer Head Retirement Controller

This block decides, every cycle, how many instructions leave the head of a reorder buffer and what the rest of the pipeline is told about them. It looks at a window of the oldest entries belonging to the thread a selector has granted, walks them in age order and retires finished work up to a fixed per-cycle commit budget. Entries that were already cancelled drain out of the buffer without using that budget. The walk ends at the first entry that is missing, not yet ready, or cannot finish in this cycle.

Entries that cannot finish produce a request instead of a retirement. A serialising instruction (non-speculative, store-conditional or either kind of barrier) that has not executed yet is sent back to execute only when it is the oldest work of the cycle and no stores are still waiting to write back. An unexecuted load is sent back to be replayed as an uncached access. A faulting instruction raises a trap under the same oldest-and-no-stores rule and blocks its thread until the trap handler reports back. Any other unexecuted entry sets an error flag. The per-cycle results go straight to the buffer so that it can pop its head in the same cycle. Two event counters and a registered free-space report are kept alongside.

Top module: `rob_retire`

## Requirements
- R1: At most W (default 4) non-cancelled instructions are committed per cycle. The walk stops at the first slot that is not valid or not ready, and nothing retires when the grant is absent or the granted thread is blocked. `retireCnt` counts every entry leaving the head and `commitCnt` counts the committed ones.
- R2: A ready cancelled entry retires without adding to `commitCnt`, and it is retired even after W commits would otherwise have been reached earlier in the window. `squashRetireCnt` grows by the number of cancelled entries retired in the cycle.
- R3: An unexecuted entry flagged non-speculative, store-conditional, memory barrier or write barrier ends the walk. This class takes priority over the load flag. If it is the first commit candidate of the cycle (`commitCnt` still 0) and `storesPending` is low, `nonSpecReq` pulses with the entry's sequence number on `nonSpecSeq`. Otherwise no request is made.
- R4: An unexecuted load that is not in the R3 class ends the walk and pulses `uncachedReq` with its sequence number on `uncachedSeq`, whatever its position.
- R5: A faulting executed entry ends the walk without retiring. If `commitCnt` is 0 and `storesPending` is low, `trapReq` pulses and the granted thread becomes blocked from the next cycle until its bit of `trapDone` is high at a clock edge.
- R6: `doneValid` is high exactly when `commitCnt` is non-zero, and `doneSeq` then carries the sequence number of the youngest instruction committed in that cycle.
- R7: `bwLimitCnt` increments by one at the edge that ends each cycle in which `commitCnt` equals W.
- R8: An unexecuted entry that is neither in the R3 class nor a load ends the walk and raises `unknownErr` for that cycle.
- R9: One cycle after a cycle with `retireCnt` above 0, `freeBcastValid` is high, `freeBcastCnt` equals the earlier `robFreeIn` plus `retireCnt`, and `robEmptyBcast` is high if that sum equals DEPTH (default 32). After a cycle with no retirement, all three are 0.
- R10: After reset, both counters are 0, every thread is unblocked and the broadcast outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grantValid | input | 1 | A thread is granted this cycle |
| grantTid | input | $clog2(NT) | Granted thread |
| hdValid | input | WIN | Window slot holds an entry (slot 0 is oldest) |
| hdReady | input | WIN | Entry may be considered for commit |
| hdSquashed | input | WIN | Entry was cancelled |
| hdExecuted | input | WIN | Entry finished execution |
| hdNonSpec | input | WIN | Entry must run non-speculatively |
| hdStoreCond | input | WIN | Entry is a store-conditional |
| hdMemBar | input | WIN | Entry is a memory barrier |
| hdWrBar | input | WIN | Entry is a write barrier |
| hdLoad | input | WIN | Entry is a load |
| hdFault | input | WIN | Entry carries a fault |
| hdSeq | input | WIN*SEQW | Sequence numbers, slot i at bits i*SEQW |
| storesPending | input | 1 | Stores still wait to write back |
| robFreeIn | input | $clog2(DEPTH+1) | Free entries before this cycle's retirement |
| trapDone | input | NT | Per-thread trap completion, unblocks the thread |
| retireCnt | output | $clog2(WIN+1) | Entries popped from the head this cycle |
| commitCnt | output | $clog2(WIN+1) | Non-cancelled entries committed this cycle |
| nonSpecReq | output | 1 | Request to execute a serialising entry |
| nonSpecSeq | output | SEQW | Sequence number for nonSpecReq |
| uncachedReq | output | 1 | Request to replay a load uncached |
| uncachedSeq | output | SEQW | Sequence number for uncachedReq |
| trapReq | output | 1 | Fault trap raised for grantTid |
| doneValid | output | 1 | At least one commit this cycle |
| doneSeq | output | SEQW | Youngest committed sequence number |
| unknownErr | output | 1 | Unexecuted entry of unknown kind at the stop point |
| bwLimitCnt | output | CTRW | Cycles that used the whole commit budget |
| squashRetireCnt | output | CTRW | Cancelled entries retired |
| freeBcastValid | output | 1 | Registered free-space report is current |
| freeBcastCnt | output | $clog2(DEPTH+1) | Registered free-entry count |
| robEmptyBcast | output | 1 | Registered report that the buffer is empty |

## Verification
Cancelled entries that retire for free and the commit budget that runs out can fall in the same cycle. They interact because only commits use the budget. Windows in which cancelled entries sit between executed ones are driven so that four commits and two cancelled retirements happen together. In that cycle the commit count, the pop count, the cancelled-retire counter and the full-budget counter are all judged against a behavioural walk in the bench. A second pairing, commits ahead of a fault or barrier in the same window, is provoked to confirm that the younger entry is held back and not acted on.

// File: rtl/retire_pkg.sv
package retire_pkg;
  // strobes from the scan control to the state datapath
  typedef struct packed {
    logic fullWidth;  // commit budget used up this cycle
    logic anyRetire;  // at least one entry left the head
    logic trapSet;    // fault trap raised for the granted thread
  } retireStrobe_t;
endpackage

// File: rtl/retire_scan.sv
module retire_scan
  import retire_pkg::*;
#(
  parameter int W    = 4,
  parameter int WIN  = 6,
  parameter int SEQW = 16,
  localparam int CNTW = $clog2(WIN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                grantOk,
  input  logic [WIN-1:0]      hdValid,
  input  logic [WIN-1:0]      hdReady,
  input  logic [WIN-1:0]      hdSquashed,
  input  logic [WIN-1:0]      hdExecuted,
  input  logic [WIN-1:0]      hdNonSpec,
  input  logic [WIN-1:0]      hdStoreCond,
  input  logic [WIN-1:0]      hdMemBar,
  input  logic [WIN-1:0]      hdWrBar,
  input  logic [WIN-1:0]      hdLoad,
  input  logic [WIN-1:0]      hdFault,
  input  logic [WIN*SEQW-1:0] hdSeq,
  input  logic                storesPending,
  output logic [CNTW-1:0]     retireCnt,
  output logic [CNTW-1:0]     commitCnt,
  output logic [CNTW-1:0]     squashCnt,
  output logic                nonSpecReq,
  output logic [SEQW-1:0]     nonSpecSeq,
  output logic                uncachedReq,
  output logic [SEQW-1:0]     uncachedSeq,
  output logic                trapReq,
  output logic                doneValid,
  output logic [SEQW-1:0]     doneSeq,
  output logic                unknownErr,
  output retireStrobe_t       strobe
);
  localparam logic [CNTW-1:0] BUDGET = CNTW'(W);
  localparam logic [CNTW-1:0] ONE    = CNTW'(1);

  logic walking;
  logic serialising;
  logic [SEQW-1:0] slotSeq;

  always_comb begin
    walking     = grantOk;
    retireCnt   = '0;
    commitCnt   = '0;
    squashCnt   = '0;
    nonSpecReq  = 1'b0;
    nonSpecSeq  = '0;
    uncachedReq = 1'b0;
    uncachedSeq = '0;
    trapReq     = 1'b0;
    doneValid   = 1'b0;
    doneSeq     = '0;
    unknownErr  = 1'b0;
    serialising = 1'b0;
    slotSeq     = '0;
    for (int i = 0; i < WIN; i++) begin
      slotSeq     = hdSeq[i*SEQW +: SEQW];
      serialising = hdNonSpec[i] | hdStoreCond[i] | hdMemBar[i] | hdWrBar[i];
      if (walking) begin
        if (commitCnt == BUDGET || !hdValid[i] || !hdReady[i]) begin
          walking = 1'b0;
        end else if (hdSquashed[i]) begin
          retireCnt = retireCnt + ONE;
          squashCnt = squashCnt + ONE;
        end else if (!hdExecuted[i]) begin
          walking = 1'b0;
          if (serialising) begin
            if (commitCnt == '0 && !storesPending) begin
              nonSpecReq = 1'b1;
              nonSpecSeq = slotSeq;
            end
          end else if (hdLoad[i]) begin
            uncachedReq = 1'b1;
            uncachedSeq = slotSeq;
          end else begin
            unknownErr = 1'b1;
          end
        end else if (hdFault[i]) begin
          walking = 1'b0;
          trapReq = (commitCnt == '0) && !storesPending;
        end else begin
          retireCnt = retireCnt + ONE;
          commitCnt = commitCnt + ONE;
          doneValid = 1'b1;
          doneSeq   = slotSeq;
        end
      end
    end
    strobe.fullWidth = (commitCnt == BUDGET);
    strobe.anyRetire = (retireCnt != '0);
    strobe.trapSet   = trapReq;
  end

  // R1 budget never exceeded
  p_budget_r1: assert property (@(posedge clk) disable iff (!rstN)
    commitCnt <= BUDGET);
  // R3/R4/R5/R8 the walk ends on at most one kind of stop action
  p_one_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nonSpecReq, uncachedReq, trapReq, unknownErr}));
  // R5 a trap is only raised with no commit ahead of it
  p_trap_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (commitCnt == '0 && !storesPending));
  // R6 done report tracks commits
  p_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid == (commitCnt != '0));
endmodule

// File: rtl/retire_state.sv
module retire_state
  import retire_pkg::*;
#(
  parameter int WIN   = 6,
  parameter int NT    = 2,
  parameter int DEPTH = 32,
  parameter int CTRW  = 16,
  localparam int CNTW  = $clog2(WIN + 1),
  localparam int TIDW  = (NT > 1) ? $clog2(NT) : 1,
  localparam int FREEW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  retireStrobe_t    strobe,
  input  logic [TIDW-1:0]  grantTid,
  input  logic [NT-1:0]    trapDone,
  input  logic [CNTW-1:0]  retireCnt,
  input  logic [CNTW-1:0]  squashCnt,
  input  logic [FREEW-1:0] robFreeIn,
  output logic             grantBlocked,
  output logic [CTRW-1:0]  bwLimitCnt,
  output logic [CTRW-1:0]  squashRetireCnt,
  output logic             freeBcastValid,
  output logic [FREEW-1:0] freeBcastCnt,
  output logic             robEmptyBcast
);
  logic [NT-1:0] trapPend;
  logic [FREEW-1:0] freeNext;

  assign grantBlocked = trapPend[grantTid];
  assign freeNext     = robFreeIn + FREEW'(retireCnt);

  for (genvar t = 0; t < NT; t++) begin : g_thread
    always_ff @(posedge clk) begin
      if (!rstN)                                          trapPend[t] <= 1'b0;
      else if (strobe.trapSet && grantTid == TIDW'(t))    trapPend[t] <= 1'b1;
      else if (trapDone[t])                               trapPend[t] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bwLimitCnt      <= '0;
      squashRetireCnt <= '0;
      freeBcastValid  <= 1'b0;
      freeBcastCnt    <= '0;
      robEmptyBcast   <= 1'b0;
    end else begin
      if (strobe.fullWidth) bwLimitCnt <= bwLimitCnt + CTRW'(1);
      squashRetireCnt <= squashRetireCnt + CTRW'(squashCnt);
      freeBcastValid  <= strobe.anyRetire;
      freeBcastCnt    <= strobe.anyRetire ? freeNext : '0;
      robEmptyBcast   <= strobe.anyRetire && (freeNext == FREEW'(DEPTH));
    end
  end

  // R5 a raised trap blocks the thread on the next cycle
  p_trap_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.trapSet && !trapDone[grantTid]) |=> trapPend[$past(grantTid)]);
  // R9 no report after a cycle without retirement
  p_bcast_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.anyRetire |=> (!freeBcastValid && !robEmptyBcast));
  // R7 budget cycle advances the limit counter
  p_bw_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fullWidth |=> bwLimitCnt == $past(bwLimitCnt) + CTRW'(1));
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import retire_pkg::*;
#(
  parameter int W     = 4,
  parameter int WIN   = 6,
  parameter int SEQW  = 16,
  parameter int NT    = 2,
  parameter int DEPTH = 32,
  parameter int CTRW  = 16,
  localparam int CNTW  = $clog2(WIN + 1),
  localparam int TIDW  = (NT > 1) ? $clog2(NT) : 1,
  localparam int FREEW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                grantValid,
  input  logic [TIDW-1:0]     grantTid,
  input  logic [WIN-1:0]      hdValid,
  input  logic [WIN-1:0]      hdReady,
  input  logic [WIN-1:0]      hdSquashed,
  input  logic [WIN-1:0]      hdExecuted,
  input  logic [WIN-1:0]      hdNonSpec,
  input  logic [WIN-1:0]      hdStoreCond,
  input  logic [WIN-1:0]      hdMemBar,
  input  logic [WIN-1:0]      hdWrBar,
  input  logic [WIN-1:0]      hdLoad,
  input  logic [WIN-1:0]      hdFault,
  input  logic [WIN*SEQW-1:0] hdSeq,
  input  logic                storesPending,
  input  logic [FREEW-1:0]    robFreeIn,
  input  logic [NT-1:0]       trapDone,
  output logic [CNTW-1:0]     retireCnt,
  output logic [CNTW-1:0]     commitCnt,
  output logic                nonSpecReq,
  output logic [SEQW-1:0]     nonSpecSeq,
  output logic                uncachedReq,
  output logic [SEQW-1:0]     uncachedSeq,
  output logic                trapReq,
  output logic                doneValid,
  output logic [SEQW-1:0]     doneSeq,
  output logic                unknownErr,
  output logic [CTRW-1:0]     bwLimitCnt,
  output logic [CTRW-1:0]     squashRetireCnt,
  output logic                freeBcastValid,
  output logic [FREEW-1:0]    freeBcastCnt,
  output logic                robEmptyBcast
);
  retireStrobe_t   strobe;
  logic            grantBlocked;
  logic [CNTW-1:0] squashCnt;

  retire_scan #(.W(W), .WIN(WIN), .SEQW(SEQW)) u_scan (
    .clk(clk), .rstN(rstN),
    .grantOk(grantValid && !grantBlocked),
    .hdValid(hdValid), .hdReady(hdReady), .hdSquashed(hdSquashed),
    .hdExecuted(hdExecuted), .hdNonSpec(hdNonSpec), .hdStoreCond(hdStoreCond),
    .hdMemBar(hdMemBar), .hdWrBar(hdWrBar), .hdLoad(hdLoad), .hdFault(hdFault),
    .hdSeq(hdSeq), .storesPending(storesPending),
    .retireCnt(retireCnt), .commitCnt(commitCnt), .squashCnt(squashCnt),
    .nonSpecReq(nonSpecReq), .nonSpecSeq(nonSpecSeq),
    .uncachedReq(uncachedReq), .uncachedSeq(uncachedSeq),
    .trapReq(trapReq), .doneValid(doneValid), .doneSeq(doneSeq),
    .unknownErr(unknownErr), .strobe(strobe)
  );

  retire_state #(.WIN(WIN), .NT(NT), .DEPTH(DEPTH), .CTRW(CTRW)) u_state (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grantTid(grantTid),
    .trapDone(trapDone), .retireCnt(retireCnt), .squashCnt(squashCnt),
    .robFreeIn(robFreeIn), .grantBlocked(grantBlocked),
    .bwLimitCnt(bwLimitCnt), .squashRetireCnt(squashRetireCnt),
    .freeBcastValid(freeBcastValid), .freeBcastCnt(freeBcastCnt),
    .robEmptyBcast(robEmptyBcast)
  );

  // R1 no retirement without a usable grant
  p_no_grant_r1: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> retireCnt == '0);
  // R2 cancelled entries never count as commits
  p_pop_ge_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    retireCnt >= commitCnt);
endmodule

// File: tb/rob_retire_bench.sv
`timescale 1ns/1ps
module rob_retire_bench;
  localparam int W = 4, WIN = 6, SEQW = 16, NT = 2, DEPTH = 32, CTRW = 16;
  localparam int CNTW = $clog2(WIN + 1), FREEW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic grantValid = 1'b0;
  logic [0:0] grantTid = '0;
  logic [WIN-1:0] vV = '0, vR = '0, vSq = '0, vEx = '0, vNs = '0, vSc = '0,
                  vMb = '0, vWb = '0, vLd = '0, vFt = '0;
  logic [WIN*SEQW-1:0] vSeq = '0;
  logic storesPending = 1'b0;
  logic [FREEW-1:0] robFreeIn = '0;
  logic [NT-1:0] trapDone = '0;

  logic [CNTW-1:0] retireCnt, commitCnt;
  logic nonSpecReq, uncachedReq, trapReq, doneValid, unknownErr;
  logic [SEQW-1:0] nonSpecSeq, uncachedSeq, doneSeq;
  logic [CTRW-1:0] bwLimitCnt, squashRetireCnt;
  logic freeBcastValid, robEmptyBcast;
  logic [FREEW-1:0] freeBcastCnt;

  rob_retire u_rob_retire (
    .clk(clk), .rstN(rstN), .grantValid(grantValid), .grantTid(grantTid),
    .hdValid(vV), .hdReady(vR), .hdSquashed(vSq), .hdExecuted(vEx),
    .hdNonSpec(vNs), .hdStoreCond(vSc), .hdMemBar(vMb), .hdWrBar(vWb),
    .hdLoad(vLd), .hdFault(vFt), .hdSeq(vSeq), .storesPending(storesPending),
    .robFreeIn(robFreeIn), .trapDone(trapDone),
    .retireCnt(retireCnt), .commitCnt(commitCnt),
    .nonSpecReq(nonSpecReq), .nonSpecSeq(nonSpecSeq),
    .uncachedReq(uncachedReq), .uncachedSeq(uncachedSeq),
    .trapReq(trapReq), .doneValid(doneValid), .doneSeq(doneSeq),
    .unknownErr(unknownErr), .bwLimitCnt(bwLimitCnt),
    .squashRetireCnt(squashRetireCnt), .freeBcastValid(freeBcastValid),
    .freeBcastCnt(freeBcastCnt), .robEmptyBcast(robEmptyBcast)
  );

  int checks = 0, failures = 0;
  // model state
  bit mPend[NT];
  int mBw = 0, mSqTot = 0, mBcV = 0, mBcC = 0, mBcE = 0;
  // model per-cycle results
  int eRet, eCom, eSq, eNs, eNsSeq, eUn, eUnSeq, eTrap, eDv, eDs, eErr;
  int seqBase = 100;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int seqOf(input int i);
    return seqBase + i;
  endfunction

  task automatic modelWalk();
    bit go;
    go = grantValid && !mPend[grantTid];
    eRet = 0; eCom = 0; eSq = 0; eNs = 0; eNsSeq = 0; eUn = 0; eUnSeq = 0;
    eTrap = 0; eDv = 0; eDs = 0; eErr = 0;
    for (int i = 0; i < WIN; i++) begin
      if (!go) break;
      if (eCom == W || !vV[i] || !vR[i]) go = 0;
      else if (vSq[i]) begin eRet++; eSq++; end
      else if (!vEx[i]) begin
        go = 0;
        if (vNs[i] || vSc[i] || vMb[i] || vWb[i]) begin
          if (eCom == 0 && !storesPending) begin eNs = 1; eNsSeq = seqOf(i); end
        end else if (vLd[i]) begin eUn = 1; eUnSeq = seqOf(i); end
        else eErr = 1;
      end else if (vFt[i]) begin
        go = 0;
        if (eCom == 0 && !storesPending) eTrap = 1;
      end else begin eRet++; eCom++; eDv = 1; eDs = seqOf(i); end
    end
  endtask

  task automatic clearWin();
    vV = '0; vR = '0; vSq = '0; vEx = '0; vNs = '0; vSc = '0;
    vMb = '0; vWb = '0; vLd = '0; vFt = '0;
  endtask

  // window of n ready executed entries
  task automatic plainWin(input int n);
    clearWin();
    for (int i = 0; i < n; i++) begin vV[i] = 1; vR[i] = 1; vEx[i] = 1; end
  endtask

  // one cycle: drive at negedge, judge comb outputs, then registered ones
  task automatic step();
    int freeNow;
    @(negedge clk);
    seqBase = seqBase + 8;
    for (int i = 0; i < WIN; i++) vSeq[i*SEQW +: SEQW] = SEQW'(seqOf(i));
    #1;
    modelWalk();
    chk("R1 retireCnt", int'(retireCnt), eRet);
    chk("R1 commitCnt", int'(commitCnt), eCom);
    chk("R3 nonSpecReq", int'(nonSpecReq), eNs);
    if (eNs != 0) chk("R3 nonSpecSeq", int'(nonSpecSeq), eNsSeq);
    chk("R4 uncachedReq", int'(uncachedReq), eUn);
    if (eUn != 0) chk("R4 uncachedSeq", int'(uncachedSeq), eUnSeq);
    chk("R5 trapReq", int'(trapReq), eTrap);
    chk("R6 doneValid", int'(doneValid), eDv);
    if (eDv != 0) chk("R6 doneSeq", int'(doneSeq), eDs);
    chk("R8 unknownErr", int'(unknownErr), eErr);
    freeNow = int'(robFreeIn);
    @(posedge clk);
    if (eTrap != 0) mPend[grantTid] = 1;
    else for (int t = 0; t < NT; t++) if (trapDone[t]) mPend[t] = 0;
    if (eCom == W) mBw++;
    mSqTot += eSq;
    mBcV = (eRet > 0); mBcC = mBcV ? freeNow + eRet : 0;
    mBcE = mBcV && (mBcC == DEPTH);
    #1;
    chk("R7 bwLimitCnt", int'(bwLimitCnt), mBw);
    chk("R2 squashRetireCnt", int'(squashRetireCnt), mSqTot);
    chk("R9 freeBcastValid", int'(freeBcastValid), mBcV);
    chk("R9 freeBcastCnt", int'(freeBcastCnt), mBcC);
    chk("R9 robEmptyBcast", int'(robEmptyBcast), mBcE);
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) mPend[t] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R10 reset state
    chk("R10 bwLimitCnt", int'(bwLimitCnt), 0);
    chk("R10 squashRetireCnt", int'(squashRetireCnt), 0);
    chk("R10 freeBcastValid", int'(freeBcastValid), 0);
    chk("R10 robEmptyBcast", int'(robEmptyBcast), 0);

    grantValid = 1; grantTid = 0; robFreeIn = 10;
    // R1/R7 six ready entries, only four commit
    plainWin(6); step();
    // R2 cancelled entries interleaved with a full budget
    plainWin(6); vSq[0] = 1; vSq[2] = 1; step();
    // R1 not-ready slot ends the walk
    plainWin(6); vR[2] = 0; step();
    // R1 no grant
    grantValid = 0; plainWin(6); step(); grantValid = 1;
    // R3 barrier behind a commit stalls
    plainWin(3); vEx[1] = 0; vMb[1] = 1; step();
    // R3 barrier first with stores pending stalls
    plainWin(3); vEx[0] = 0; vWb[0] = 1; storesPending = 1; step();
    // R3 barrier first, no stores, wins over load flag
    storesPending = 0; plainWin(3); vEx[0] = 0; vNs[0] = 1; vLd[0] = 1; step();
    // R4 load behind commits and a cancelled entry
    plainWin(4); vSq[0] = 1; vEx[2] = 0; vLd[2] = 1; step();
    // R8 unknown unexecuted
    plainWin(4); vEx[1] = 0; step();
    // R5 fault behind a commit waits
    plainWin(3); vFt[1] = 1; step();
    // R5 fault first with stores pending waits
    plainWin(3); vFt[0] = 1; storesPending = 1; step();
    // R5 fault first raises trap, thread 0 then blocked
    storesPending = 0; plainWin(3); vFt[0] = 1; step();
    plainWin(3); step();
    // R5 other thread still commits
    grantTid = 1; plainWin(3); step();
    grantTid = 0; trapDone = 2'b01; plainWin(3); step();
    trapDone = 0; plainWin(3); step();
    // R9 free count reaching depth
    robFreeIn = FREEW'(DEPTH - 4); plainWin(6); step();
    // random mix
    for (int n = 0; n < 400; n++) begin
      clearWin();
      for (int i = 0; i < WIN; i++) begin
        vV[i] = ($urandom_range(9) != 0); vR[i] = ($urandom_range(7) != 0);
        vSq[i] = ($urandom_range(3) == 0); vEx[i] = ($urandom_range(6) != 0);
        vNs[i] = ($urandom_range(7) == 0); vSc[i] = ($urandom_range(15) == 0);
        vMb[i] = ($urandom_range(15) == 0); vWb[i] = ($urandom_range(15) == 0);
        vLd[i] = ($urandom_range(3) == 0); vFt[i] = ($urandom_range(9) == 0);
      end
      storesPending = ($urandom_range(3) == 0);
      grantValid = ($urandom_range(9) != 0);
      grantTid = 1'($urandom_range(1));
      trapDone = 2'($urandom_range(3)) & {($urandom_range(3) == 0), ($urandom_range(3) == 0)};
      robFreeIn = FREEW'($urandom_range(DEPTH - WIN));
      step();
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule